// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Transceiver

The block moves 8-bit frames over a serial output and a serial input at the same time. Both directions are timed by one internal serial clock, which runs free from reset and is also brought out on a pin. Each bit lasts `CLK_DIV` system clock cycles. Software reaches the block through a small register bus with four addresses. A DMA engine can use two dedicated strobes instead of the bus.

A transmit holding register feeds a transmit shift register. A receive shift register feeds a receive holding register. Three flags control the handshake:
- transmit-empty: the holding register may be written.
- receive-full: a frame is waiting to be read.
- overrun: a frame arrived while receive-full was still set.

Software clears a flag by reading it as 1 and then writing 0 to it. A DMA access clears its own flag with no extra write. Each of the two "ready" flags sends a one-cycle interrupt pulse when it rises. While overrun is set, the receiver is frozen.

Top module: `ser_xcvr`

## Requirements
- R1: After reset, control reads 0 and status reads 0x01 (only transmit-empty is set). `txd_o` is high and both interrupt outputs are low.
- R2: The register addresses on `sel_i` are as follows.
  - 0 is control: bit 0 is transmit enable, bit 1 is receive enable.
  - 1 is status: bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is overrun.
  - 2 is the transmit holding register.
  - 3 is the receive holding register.
  - Unused bits read 0.
- R3: While transmit is enabled and transmit-empty is 0, the next serial clock tick moves the holding register into the shifter and sets transmit-empty.
  - `irq_txe_o` is high for exactly the one cycle in which the flag becomes 1.
  - The frame goes out LSB first, one bit per `CLK_DIV` cycles.
- R4: If transmit-empty is 1 at a frame boundary, no frame starts and `txd_o` stays high. `txd_o` is also high one cycle after transmit enable is 0.
- R5: If new data is pending when bit 7 ends, the next frame follows with no idle bit between the frames.
- R6: While receive is enabled, `rxd_i` is sampled on every tick.
  - Eight samples form a byte, LSB first.
  - If receive-full was 0, the byte is written to the receive holding register and receive-full is set.
  - `irq_rxf_o` pulses for one cycle when receive-full is set.
- R7: A frame that completes while receive-full is 1 sets overrun. The receive holding register keeps its old value.
- R8: While overrun is 1, no bits are shifted in and no frame completes. Reception resumes once overrun is cleared.
- R9: Writing 0 to a status flag clears it only if the last status read since the last status write returned 1 for that flag. Writing 1 to a flag has no effect.
- R10: `dma_wr_i` loads `wdata_i` into the transmit holding register and clears transmit-empty. `dma_rd_i` returns the receive holding register on `rdata_o` and clears receive-full.
- R11: A control write that sets both enables is ignored when exactly one enable is currently set. The same write is accepted from the state with both enables cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (arms flag clearing when the address is status) |
| wdata_i | input | DW | Write data for the bus and for DMA writes |
| rdata_o | output | DW | Read data for the addressed register, or receive data during a DMA read |
| dma_wr_i | input | 1 | DMA write of transmit data |
| dma_rd_i | input | 1 | DMA read of receive data |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Internal serial clock; falls at every bit boundary |
| irq_txe_o | output | 1 | Transmit-empty interrupt pulse |
| irq_rxf_o | output | 1 | Receive-full interrupt pulse |

## Verification
The bench looks at several boundary cases that a wrong design would get visibly wrong.

Two frames are sent back to back, with the second byte supplied by DMA during the first frame. A transmitter that checked for new data one bit late would insert a high bit between the frames.

Three receive frames arrive with nobody reading. An overrun check that was missing would overwrite the held byte with the second frame. A freeze that was missing would let the third frame complete.

Flag writes are tested three ways: without a prior read, with 1, and as a selective clear of overrun only. A design that cleared on any write of 0, or cleared every flag at once, would show up here.

Control writes that jump straight from one enable to both must read back unchanged.

// File: rtl/ser_xcvr_pkg.sv
package ser_xcvr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_RXD  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_TX = 0;
  localparam int unsigned CTRL_RX = 1;
  localparam int unsigned ST_TXE  = 0;
  localparam int unsigned ST_RXF  = 1;
  localparam int unsigned ST_OVR  = 2;

  // bit order matches the status register layout
  typedef struct packed {
    logic ovr;
    logic rxf;
    logic txe;
  } flags_t;
endpackage

// File: rtl/ser_tick.sv
module ser_tick #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic sclk_o
);
  localparam int unsigned TW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);
  localparam logic [TW-1:0] HALF = TW'(DIV / 2);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
  assign sclk_o = (cnt_q >= HALF);

  assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          pend_i,
  input  logic [DW-1:0] data_i,
  output logic          load_o,
  output logic          txd_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          last;

  assign last   = (cnt_q == LAST);
  // start from idle, or chain straight on at the end of bit 7
  assign load_o = tick_i && en_i && pend_i && (!busy_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (load_o) begin
        sh_q   <= data_i;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd_o = busy_q ? sh_q[0] : 1'b1;

  assert_off_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> txd_o);
  assert_load_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_q);
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        sh_q   <= {rxd_i, sh_q[DW-1:1]};
        cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        done_q <= (cnt_q == LAST);
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/ser_xcvr.sv
module ser_xcvr
  import ser_xcvr_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_DIV = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          dma_wr_i,
  input  logic          dma_rd_i,
  output logic          txd_o,
  input  logic          rxd_i,
  output logic          sclk_o,
  output logic          irq_txe_o,
  output logic          irq_rxf_o
);
  logic          tick, tx_load, rx_done;
  logic          tx_en_q, rx_en_q;
  flags_t        flg_q, flg_d, arm_q;
  logic [DW-1:0] tdr_q, rdr_q, rx_data;
  logic          irq_txe_q, irq_rxf_q;
  logic          ctrl_wr, stat_wr, stat_rd, tdr_wr, dup_bad;
  logic          clr_txe, clr_rxf, clr_ovr;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);
  assign stat_wr = wr_i && (sel_i == SEL_STAT);
  assign stat_rd = rd_i && (sel_i == SEL_STAT);
  assign tdr_wr  = wr_i && (sel_i == SEL_TXD);

  // flag clear needs a prior read that returned 1
  assign clr_txe = stat_wr && arm_q.txe && !wdata_i[ST_TXE];
  assign clr_rxf = stat_wr && arm_q.rxf && !wdata_i[ST_RXF];
  assign clr_ovr = stat_wr && arm_q.ovr && !wdata_i[ST_OVR];

  // both enables may only be set together from the all-off state
  assign dup_bad = wdata_i[CTRL_TX] && wdata_i[CTRL_RX] && (tx_en_q ^ rx_en_q);

  ser_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick),
    .sclk_o (sclk_o)
  );

  ser_tx #(.DW(DW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (tx_en_q),
    .pend_i (!flg_q.txe),
    .data_i (tdr_q),
    .load_o (tx_load),
    .txd_o  (txd_o)
  );

  ser_rx #(.DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (rx_en_q && !flg_q.ovr),
    .rxd_i  (rxd_i),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  always_comb begin
    flg_d = flg_q;
    if (tx_load)              flg_d.txe = 1'b1;
    if (clr_txe || dma_wr_i)  flg_d.txe = 1'b0;  // pending write wins over load
    if (rx_done) begin
      if (flg_q.rxf)          flg_d.ovr = 1'b1;
      else                    flg_d.rxf = 1'b1;
    end
    if (clr_rxf || dma_rd_i)  flg_d.rxf = 1'b0;
    if (clr_ovr)              flg_d.ovr = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      flg_q     <= '{ovr: 1'b0, rxf: 1'b0, txe: 1'b1};
      arm_q     <= '0;
      tdr_q     <= '0;
      rdr_q     <= '0;
      irq_txe_q <= 1'b0;
      irq_rxf_q <= 1'b0;
    end else begin
      if (ctrl_wr && !dup_bad) begin
        tx_en_q <= wdata_i[CTRL_TX];
        rx_en_q <= wdata_i[CTRL_RX];
      end
      if (tdr_wr || dma_wr_i) tdr_q <= wdata_i;
      if (rx_done && !flg_q.rxf) rdr_q <= rx_data;
      if (stat_rd)      arm_q <= flg_q;
      else if (stat_wr) arm_q <= '0;
      flg_q     <= flg_d;
      irq_txe_q <= flg_d.txe && !flg_q.txe;
      irq_rxf_q <= flg_d.rxf && !flg_q.rxf;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dma_rd_i) begin
      rdata_o = rdr_q;
    end else begin
      unique case (sel_i)
        SEL_CTRL: rdata_o = {{(DW-2){1'b0}}, rx_en_q, tx_en_q};
        SEL_STAT: rdata_o = {{(DW-3){1'b0}}, flg_q};
        SEL_TXD:  rdata_o = tdr_q;
        SEL_RXD:  rdata_o = rdr_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_txe_o = irq_txe_q;
  assign irq_rxf_o = irq_rxf_q;

  assert_txe_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_txe_o |=> !irq_txe_o);
  assert_rxf_irq_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rxf_o |-> flg_q.rxf);
  assert_rdr_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_q.ovr |=> $stable(rdr_q));
  assert_rx_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_q.ovr |-> !rx_done);
  assert_dup_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_q && rx_en_q) |-> $past(!tx_en_q && !rx_en_q));
endmodule

// File: tb/ser_xcvr_test.sv
`timescale 1ns/1ps
module ser_xcvr_test;
  localparam int unsigned DW = 8;
  localparam int unsigned DIV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          dma_wr = 1'b0, dma_rd = 1'b0;
  logic          txd, rxd = 1'b1, sclk, irq_txe, irq_rxf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ser_xcvr #(.DW(DW), .CLK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dma_wr_i(dma_wr), .dma_rd_i(dma_rd),
    .txd_o(txd), .rxd_i(rxd), .sclk_o(sclk),
    .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic dma_write(input logic [7:0] d);
    @(negedge clk); wdata = d; dma_wr = 1'b1;
    @(negedge clk); dma_wr = 1'b0;
  endtask

  task automatic dma_read(output logic [7:0] d);
    @(negedge clk); dma_rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); dma_rd = 1'b0;
  endtask

  task automatic wait_txe_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (irq_txe) seen = 1;
    end
  endtask

  task automatic rx_bits(input logic [7:0] b, input bit first);
    if (first) begin
      @(negedge sclk); @(negedge clk);
      rxd = b[0];
      bus_wr(2'd0, 8'h02);
    end else begin
      @(negedge sclk); @(negedge clk);
      rxd = b[0];
    end
    for (int i = 1; i < 8; i++) begin
      @(negedge sclk); @(negedge clk);
      rxd = b[i];
    end
  endtask

  task automatic rx_stop(output int irqs);
    irqs = 0;
    @(negedge sclk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (irq_rxf) irqs++;
    end
    bus_wr(2'd0, 8'h00);
    rxd = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(2'd0, d); chk("R1 ctrl after reset", d, 8'h00);
    bus_rd(2'd1, d); chk("R1 status after reset", d, 8'h01);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 irqs low", {irq_txe, irq_rxf}, 2'b00);
    bus_rd(2'd3, d); chk("R2 rx data reads 0", d, 8'h00);
  endtask

  task automatic t_tx_idle;
    logic [7:0] d;
    int lows = 0;
    int irqs = 0;
    bus_wr(2'd0, 8'h01);
    repeat (3 * DIV) begin
      @(negedge clk);
      if (!txd) lows++;
      if (irq_txe) irqs++;
    end
    chk("R4 txd stays high with empty holding reg", lows, 0);
    chk("R4 no txe irq while idle", irqs, 0);
    bus_rd(2'd0, d); chk("R2 ctrl tx enable readback", d, 8'h01);
  endtask

  task automatic t_tx_frame;
    logic [7:0] d, v;
    bit seen;
    bus_wr(2'd2, 8'hA5);
    bus_rd(2'd1, d);
    bus_wr(2'd1, 8'hFE);
    wait_txe_irq(seen);
    chk("R3 txe irq on load", seen, 1'b1);
    v[0] = txd;
    @(negedge clk);
    chk("R3 txe irq one cycle", irq_txe, 1'b0);
    for (int i = 1; i < 8; i++) begin
      @(negedge sclk); @(negedge clk);
      v[i] = txd;
    end
    chk("R3 frame LSB first", v, 8'hA5);
    @(negedge sclk); @(negedge clk);
    chk("R4 idle after frame", txd, 1'b1);
    bus_rd(2'd1, d); chk("R3 txe set after load", d, 8'h01);
  endtask

  task automatic t_tx_dma_chain;
    logic [15:0] v;
    bit seen;
    dma_write(8'h3C);
    wait_txe_irq(seen);
    chk("R10 dma write starts frame", seen, 1'b1);
    v[0] = txd;
    dma_write(8'h96);
    for (int i = 1; i < 16; i++) begin
      @(negedge sclk); @(negedge clk);
      v[i] = txd;
    end
    chk("R5 back-to-back frames", v, 16'h963C);
  endtask

  task automatic t_duplex_entry;
    logic [7:0] d;
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, d); chk("R11 tx-only to both ignored", d, 8'h01);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, d); chk("R11 off to both accepted", d, 8'h03);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'h02);
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, d); chk("R11 rx-only to both ignored", d, 8'h02);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_rx_frame;
    logic [7:0] d;
    int n;
    rx_bits(8'h5A, 1'b1);
    rx_stop(n);
    chk("R6 one rxf irq pulse", n, 1);
    bus_rd(2'd1, d); chk("R6 rxf set", d, 8'h03);
    bus_rd(2'd3, d); chk("R6 rx byte LSB first", d, 8'h5A);
  endtask

  task automatic t_flag_rules;
    logic [7:0] d;
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, d); chk("R9 unarmed and write-1 have no effect", d, 8'h03);
  endtask

  task automatic t_dma_read;
    logic [7:0] d;
    dma_read(d);
    chk("R10 dma read data", d, 8'h5A);
    bus_rd(2'd1, d); chk("R10 dma read clears rxf", d, 8'h01);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    int n;
    rx_bits(8'h11, 1'b1);
    rx_bits(8'h22, 1'b0);
    rx_bits(8'h33, 1'b0);
    rx_stop(n);
    bus_rd(2'd1, d); chk("R7 overrun flagged", d, 8'h07);
    bus_rd(2'd3, d); chk("R7 R8 holding reg keeps first byte", d, 8'h11);
    bus_rd(2'd1, d);
    bus_wr(2'd1, 8'hFB);
    bus_rd(2'd1, d); chk("R9 armed clear of overrun only", d, 8'h03);
    dma_read(d);
    chk("R10 dma read after overrun", d, 8'h11);
    rx_bits(8'hC3, 1'b1);
    rx_stop(n);
    chk("R8 reception resumes irq", n, 1);
    bus_rd(2'd3, d); chk("R8 byte after resume", d, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_idle();
    t_tx_frame();
    t_tx_dma_chain();
    t_duplex_entry();
    t_rx_frame();
    t_flag_rules();
    t_dma_read();
    t_overrun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule